// File: doc/BRIEF.md
# Radix Page-Directory Walker

This block translates an effective address by walking a multi-level radix page directory in memory. A walk starts with a pulse on `start`. With that pulse the caller supplies the root directory base, the remaining translation shift, the root index width, and the access kind: privileged or not, load, store or instruction fetch. For each level the walker forms the address of one 8-byte entry from the directory base and the effective-address index bits. It issues a single read and waits for the memory acknowledge. It then decodes the entry it received.

A non-leaf entry supplies the base and the index width of the next level. A leaf entry goes through an access check and a reference/change check. If both checks pass, the walker forms the physical address and reports the page attribute. Every other way the walk can end is reported as an error code. The result is held on the outputs, with `done` high, until the next `start`.

Top module: `radix_walker`

## Requirements
- R1: After reset, `done` and `mem_req` are low and `err` is 0.
- R2: Each level issues exactly one read, as a one-cycle `mem_req` pulse. The entry address is built from most to least significant bits: 8 zero bits, base[55:19], then (base[18:3] AND NOT m) OR (idx AND m), then 3 zero bits. Here m has its low `size` bits set, and idx is bits 15:0 of the effective address shifted right by (shift + 12).
- R3: An entry with bit 63 (valid) clear ends the walk with `err` = 1.
- R4: The walk ends with `err` = 2 (bad tree) in two cases. The first is a root index width outside 5..16, which ends the walk before any read. The second is a non-leaf entry (bit 62 clear) whose next-level width, bits 4:0, is below 5, above 16, or above the remaining shift.
- R5: For any other non-leaf entry, the remaining shift is reduced by that width, the index width becomes that width, and the next base becomes {entry[55:8], 8'h00}.
- R6: For a data access to a leaf entry, the access check passes only if the access is privileged or entry bit 3 is clear, and in addition bit 1 is set, or the access is a load and bit 2 is set. A failed access check gives `err` = 3.
- R7: For an instruction fetch, the access check passes only if the privilege condition of R6 holds, bit 0 is set and bit 5 is clear. A fetch is never treated as a store.
- R8: The reference/change check passes when bit 8 is set and, in addition, bit 7 is set or the access is not a store. If it fails while the access check passed, `err` = 4. If both checks fail, `err` = 3.
- R9: When a leaf passes both checks, `err` = 0. `paddr` is formed from 8 zero bits, then (entry[55:12] AND NOT f) OR (vaddr[55:12] AND f), then entry[11:0], where f has its low (remaining shift) bits set. `attr` = entry[5:4] (00 normal, 01 strongly ordered, 10 non-idempotent I/O, 11 tolerant I/O).
- R10: If the 8th entry read is still a valid non-leaf, the walk ends with `err` = 2 and issues no 9th read.
- R11: While `done` is high and no `start` arrives, `paddr`, `attr` and `err` stay unchanged. On any error, `paddr` and `attr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle or done) |
| vaddr | input | 64 | Effective address to translate |
| root_base | input | 53 | Root directory base, bits 55:3 |
| root_shift | input | 6 | Remaining translation shift at the root |
| root_size | input | 5 | Root index width in bits |
| priv | input | 1 | Privileged access |
| store | input | 1 | Access is a store |
| fetch | input | 1 | Access is an instruction fetch |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Entry address of the read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read from memory |
| done | output | 1 | Walk finished, result valid |
| err | output | 3 | 0 ok, 1 invalid, 2 bad tree, 3 access, 4 ref/change |
| paddr | output | 64 | Physical address |
| attr | output | 2 | Page attribute |

## Verification
The bench goes after the entry-address merge at each level and the walk-ending corner cases. A walker that indexed with the wrong shift or mask would read the wrong address at some level. A walker that checked the wrong width bounds, or skipped the width-versus-shift check, would descend where it must stop. The bench also pits the access fault against the ref/change fault on the same leaf, where a walker with the wrong priority reports 4 instead of 3. It covers fetches of cache-inhibited pages, unprivileged access to privileged pages, and stores to unchanged pages. It runs a chain of eight non-leaf entries, where a wrong level limit shows up as a 9th read or a premature stop.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int MAX_LEVELS = 8,
  localparam int LVL_W = $clog2(MAX_LEVELS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] vaddr,
  input  logic [55:3] root_base,
  input  logic [5:0]  root_shift,
  input  logic [4:0]  root_size,
  input  logic        priv,
  input  logic        store,
  input  logic        fetch,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata,
  output logic        done,
  output logic [2:0]  err,
  output logic [63:0] paddr,
  output logic [1:0]  attr
);
  localparam logic [2:0] E_OK = 3'd0, E_INV = 3'd1, E_BAD = 3'd2, E_PERM = 3'd3, E_RC = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_CHECK, S_DONE} st_t;
  st_t st;

  logic [5:0]       shift_q;
  logic [4:0]       size_q;
  logic [55:3]      base_q;
  logic [LVL_W-1:0] lvl_q;
  logic [63:0]      ent_q, vaddr_q;
  logic             priv_q, store_q, fetch_q;

  logic [15:0] mask16, addrsh;
  logic [43:0] fmask;
  logic [4:0]  nls;
  logic        bad_nls, perm_ok, rc_ok;

  assign mask16   = ~(16'hFFFF << size_q);
  assign addrsh   = 16'(vaddr_q >> (7'(shift_q) + 7'd12));
  assign mem_addr = {8'h00, base_q[55:19], (base_q[18:3] & ~mask16) | (addrsh & mask16), 3'b000};
  assign mem_req  = (st == S_REQ);
  assign done     = (st == S_DONE);

  assign nls     = ent_q[4:0];
  assign bad_nls = (nls < 5'd5) || (nls > 5'd16) || ({1'b0, nls} > shift_q);
  assign fmask   = ~({44{1'b1}} << shift_q);
  assign rc_ok   = ent_q[8] & (ent_q[7] | ~store_q);

  always_comb begin
    perm_ok = 1'b0;
    if (priv_q || !ent_q[3])
      perm_ok = fetch_q ? (ent_q[0] & ~ent_q[5]) : (ent_q[1] | (ent_q[2] & ~store_q));
  end

  wire unused_bits = ^ent_q[61:56];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      shift_q <= '0; size_q <= '0; base_q <= '0; lvl_q <= '0;
      ent_q <= '0; vaddr_q <= '0;
      priv_q <= 1'b0; store_q <= 1'b0; fetch_q <= 1'b0;
      err <= E_OK; paddr <= '0; attr <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          vaddr_q <= vaddr;
          base_q  <= root_base;
          shift_q <= root_shift;
          size_q  <= root_size;
          priv_q  <= priv;
          store_q <= store & ~fetch;
          fetch_q <= fetch;
          lvl_q   <= '0;
          paddr   <= '0;
          attr    <= '0;
          if (root_size < 5'd5 || root_size > 5'd16) begin
            err <= E_BAD;
            st  <= S_DONE;
          end else begin
            err <= E_OK;
            st  <= S_REQ;
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (mem_ack) begin
          ent_q <= mem_rdata;
          lvl_q <= lvl_q + 1'b1;
          st    <= S_CHECK;
        end
        S_CHECK: begin
          if (!ent_q[63]) begin
            err <= E_INV;
            st  <= S_DONE;
          end else if (ent_q[62]) begin
            st <= S_DONE;
            if (!perm_ok)     err <= E_PERM;
            else if (!rc_ok)  err <= E_RC;
            else begin
              paddr <= {8'h00, (ent_q[55:12] & ~fmask) | (vaddr_q[55:12] & fmask), ent_q[11:0]};
              attr  <= ent_q[5:4];
            end
          end else if (bad_nls || lvl_q == LVL_W'(MAX_LEVELS)) begin
            err <= E_BAD;
            st  <= S_DONE;
          end else begin
            shift_q <= shift_q - {1'b0, nls};
            size_q  <= nls;
            base_q  <= {ent_q[55:8], 5'b00000};
            st      <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req);
  // R10
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> lvl_q < LVL_W'(MAX_LEVELS));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(paddr) && $stable(attr) && $stable(err)));
  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err != E_OK) |-> (paddr == '0 && attr == '0));
  // R8
  perm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && ent_q[63] && ent_q[62] && !perm_ok) |=> (err == E_PERM));
endmodule

// File: tb/radix_walker_bench.sv
module radix_walker_bench;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] vaddr = '0;
  logic [55:3] root_base = '0;
  logic [5:0]  root_shift = '0;
  logic [4:0]  root_size = '0;
  logic        priv = 1'b0, store = 1'b0, fetch = 1'b0;
  logic        mem_req, mem_ack = 1'b0, done;
  logic [63:0] mem_addr, mem_rdata = '0, paddr;
  logic [2:0]  err;
  logic [1:0]  attr;

  radix_walker u_radix_walker (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [63:0] ent [0:8];
  logic [63:0] exp_addr [0:8];
  int          nexp;
  logic [2:0]  x_err;
  logic [63:0] x_paddr;
  logic [1:0]  x_attr;
  string       x_tag;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    int sh; logic [4:0] sz, n; logic [55:3] base; logic [15:0] m, idx;
    logic [63:0] e; logic [43:0] fm; logic pok, rok, st_eff;
    nexp = 0; x_err = 0; x_paddr = '0; x_attr = '0; x_tag = "R9";
    sh = root_shift; sz = root_size; base = root_base;
    st_eff = store && !fetch;
    if (sz < 5 || sz > 16) begin x_err = 2; x_tag = "R4"; return; end
    for (int i = 0; i < 8; i++) begin
      m = 16'((32'h1 << sz) - 1);
      idx = 16'(vaddr >> (sh + 12));
      exp_addr[i] = {8'h00, base[55:19], (base[18:3] & ~m) | (idx & m), 3'b000};
      nexp = i + 1;
      e = ent[i];
      if (!e[63]) begin x_err = 1; x_tag = "R3"; return; end
      if (e[62]) begin
        pok = 0;
        if (priv || !e[3]) pok = fetch ? (e[0] && !e[5]) : (e[1] || (e[2] && !st_eff));
        rok = e[8] && (e[7] || !st_eff);
        if (!pok) begin x_err = 3; x_tag = fetch ? "R7" : "R6"; end
        else if (!rok) begin x_err = 4; x_tag = "R8"; end
        else begin
          fm = (sh >= 44) ? {44{1'b1}} : 44'((64'h1 << sh) - 1);
          x_paddr = {8'h00, (e[55:12] & ~fm) | (vaddr[55:12] & fm), e[11:0]};
          x_attr = e[5:4];
        end
        return;
      end
      n = e[4:0];
      if (n < 5 || n > 16 || int'(n) > sh) begin x_err = 2; x_tag = "R4"; return; end
      if (i == 7) begin x_err = 2; x_tag = "R10"; return; end
      sh = sh - int'(n); sz = n; base = {e[55:8], 5'b00000};
    end
  endtask

  task automatic run();
    int nr = 0, guard = 0;
    logic [63:0] p0; logic [2:0] e0;
    model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && guard < 400) begin
      if (mem_req) begin
        if (nr < nexp) chk(nr == 0 ? "R2" : "R5", "entry address", mem_addr, exp_addr[nr]);
        else chk("R10", "unexpected read", 64'(nr), 64'(nexp));
        @(negedge clk);
        repeat ($urandom % 3) @(negedge clk);
        mem_ack = 1'b1; mem_rdata = ent[nr];
        @(negedge clk);
        mem_ack = 1'b0;
        nr++;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk("R2", "read count", 64'(nr), 64'(nexp));
    chk(x_tag, "err", 64'(err), 64'(x_err));
    chk(x_tag == "R9" ? "R9" : "R11", "paddr", paddr, x_paddr);
    chk(x_tag == "R9" ? "R9" : "R11", "attr", 64'(attr), 64'(x_attr));
    p0 = paddr; e0 = err;
    repeat (2) @(negedge clk);
    chk("R11", "held done", 64'(done), 64'd1);
    chk("R11", "held paddr", paddr, p0);
    chk("R11", "held err", 64'(err), 64'(e0));
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [63:0] nonleaf(logic [4:0] n);
    logic [63:0] e = r64();
    e[63] = 1'b1; e[62] = 1'b0; e[4:0] = n;
    return e;
  endfunction

  function automatic logic [63:0] leaf(logic [11:0] low);
    logic [63:0] e = r64();
    e[63] = 1'b1; e[62] = 1'b1; e[11:0] = low;
    return e;
  endfunction

  task automatic setup(logic [5:0] sh, logic [4:0] sz, logic p, logic s, logic f);
    vaddr = r64(); root_base = 53'(r64());
    root_shift = sh; root_size = sz; priv = p; store = s; fetch = f;
    for (int i = 0; i < 9; i++) ent[i] = r64();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset done", 64'(done), 64'd0);
    chk("R1", "reset mem_req", 64'(mem_req), 64'd0);
    chk("R1", "reset err", 64'(err), 64'd0);

    // R3 invalid root entry
    setup(6'd30, 5'd13, 1, 0, 0); ent[0][63] = 1'b0; run();
    // R4 width below 5, above 16, above shift, bad root width
    setup(6'd30, 5'd9, 1, 0, 0); ent[0] = nonleaf(5'd4); run();
    setup(6'd30, 5'd9, 1, 0, 0); ent[0] = nonleaf(5'd17); run();
    setup(6'd10, 5'd9, 1, 0, 0); ent[0] = nonleaf(5'd11); run();
    setup(6'd30, 5'd3, 1, 0, 0); run();
    // R5 + R9 two-level descend to good leaf
    setup(6'd30, 5'd13, 1, 0, 0); ent[0] = nonleaf(5'd9);
    ent[1] = leaf(12'h187); run();
    // R8 both checks fail on store: access fault wins
    setup(6'd20, 5'd8, 1, 1, 0); ent[0] = leaf(12'h000); run();
    // R8 ref/change only: store to unchanged page
    setup(6'd20, 5'd8, 1, 1, 0); ent[0] = leaf(12'h102); run();
    // R7 fetch from cache-inhibited page
    setup(6'd20, 5'd8, 1, 0, 1); ent[0] = leaf(12'h121); run();
    // R7 fetch allowed, store flag ignored for fetch
    setup(6'd20, 5'd8, 1, 1, 1); ent[0] = leaf(12'h101); run();
    // R6 unprivileged access to privileged page
    setup(6'd20, 5'd8, 0, 0, 0); ent[0] = leaf(12'h18a); run();
    // R10 chain of eight non-leaf entries
    setup(6'd63, 5'd5, 1, 0, 0);
    for (int i = 0; i < 9; i++) ent[i] = nonleaf(5'd5);
    run();

    for (int k = 0; k < 400; k++) begin
      int depth;
      setup(6'(20 + $urandom % 40), 5'(($urandom % 20 == 0) ? 18 : 5 + $urandom % 12),
            1'($urandom), 1'($urandom), ($urandom % 4) == 0);
      depth = $urandom % 5;
      for (int i = 0; i < 9; i++) begin
        if (i < depth) ent[i] = nonleaf(5'(($urandom % 15 == 0) ? $urandom % 32 : 5 + $urandom % 6));
        else begin
          ent[i] = leaf(12'($urandom));
          if ($urandom % 4 != 0) ent[i][8] = 1'b1;
        end
        if ($urandom % 12 == 0) ent[i][63] = 1'b0;
      end
      run();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule